// File: doc/BRIEF.md
# SD Host System-Test Logic

This block is the board-test section of an SD/SDIO host controller. A test register holds one bit per card-side pin: out-of-band interrupt, card detect, write protect and wake. While the test-mode input is high, those bits drive the pins, so a tester can toggle each pin and check the board wiring. While test mode is low, the pins follow the controller's normal functional logic, and the register still holds and reads back its stored values.

In test mode, writes to the command register start nothing, and the data port becomes a host-only stack. A write pushes and a read pops. The block register's length and count fields pace two events: a space-available event (status bit 4) while writing and a data-available event (status bit 5) while reading. Both also feed a DMA request when DMA is enabled. A sticky force bit in the test register sets every enabled interrupt status bit at once. While that bit is set, it also blocks write-1-to-clear on the status register.

Registers sit on word addresses of a 3-bit register bus: command 0, block 1, status 2, signal enable 3, test 4, data 5, control 6. Control bit 0 enables DMA. Control bit 1 selects the direction: 0 is write (push), 1 is read (pop). Block register bits 10:0 hold the block length in words, and bits 31:16 hold the block count.

Top module: `sdh_systest`

## Requirements
- R1: Test register bits 16 (out-of-band), 15 (card detect), 14 (write protect), 13 (wake) and 12 (force) are read/write and reset to 0. All other bits read 0.
- R2: With test mode high, each pin output equals its test register bit (0 low, 1 high). With test mode low, each pin output equals its functional input and the stored bits are kept.
- R3: A command write with test mode low pulses the transfer-start output high for the single cycle after the write. With test mode high, it produces no pulse.
- R4: In test mode, data-port writes push words and data-port reads return the most recently pushed word and pop it (last in, first out).
- R5: A push to a full stack is dropped and a pop from an empty stack returns 0. Either case sets sticky status bit 15.
- R6: Status bit 4 is set when space-available rises. Space-available means test mode is on, the direction is write, the remaining count is non-zero, the length is non-zero, and free entries are at least the length.
- R7: Status bit 5 is set when data-available rises. Data-available means test mode is on, the direction is read, the remaining count is non-zero, the length is non-zero, and the occupied entries are at least the length.
- R8: A block-register write loads the remaining count. Each length-th counted push (write direction) or pop (read direction) decrements it. At 0, neither ready condition holds.
- R9: The DMA request equals control bit 0 AND the ready condition of the active direction.
- R10: Writing 1 to test bit 12 sets every status bit whose enable bit is set and leaves the others unchanged.
- R11: While test bit 12 is set, status writes clear nothing. Writing 0 to bit 12 clears only bit 12.
- R12: The interrupt output is high exactly when some status bit and its enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| test_mode_i | input | 1 | System-test mode enable |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (pops on the data address) |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from the address |
| func_obi_i | input | 1 | Functional out-of-band interrupt level |
| func_cd_i | input | 1 | Functional card-detect level |
| func_wp_i | input | 1 | Functional write-protect level |
| func_wake_i | input | 1 | Functional wake level |
| pin_obi_o | output | 1 | Out-of-band interrupt pin |
| pin_cd_o | output | 1 | Card-detect pin |
| pin_wp_o | output | 1 | Write-protect pin |
| pin_wake_o | output | 1 | Wake pin |
| xfer_start_o | output | 1 | One-cycle transfer-start pulse |
| irq_o | output | 1 | Interrupt output |
| dma_req_o | output | 1 | DMA request |

## Verification
Register, stack and status updates land on the clock edge that ends a write, so each is visible one edge after the strobe. The bench drives strobes at the falling edge and samples at the next falling edge. The transfer-start pulse is sampled in that same window, one edge after the command write. A status event from a ready edge needs one more edge for its rise detector, so status reads are made only after an idle cycle. Pin, interrupt, DMA and read-data outputs are combinational from register state and are sampled mid-cycle.

// File: rtl/sdh_st_pkg.sv
package sdh_st_pkg;
  localparam int REG_AW = 3;
  localparam int DATA_W = 32;
  localparam int STAT_W = 16;
  localparam int LEN_W  = 11;
  localparam int CNT_W  = 16;

  localparam logic [REG_AW-1:0] ADR_CMD  = 3'd0;
  localparam logic [REG_AW-1:0] ADR_BLK  = 3'd1;
  localparam logic [REG_AW-1:0] ADR_STAT = 3'd2;
  localparam logic [REG_AW-1:0] ADR_SEN  = 3'd3;
  localparam logic [REG_AW-1:0] ADR_TEST = 3'd4;
  localparam logic [REG_AW-1:0] ADR_DATA = 3'd5;
  localparam logic [REG_AW-1:0] ADR_CTRL = 3'd6;

  localparam int TB_OBI  = 16;
  localparam int TB_CD   = 15;
  localparam int TB_WP   = 14;
  localparam int TB_WAKE = 13;
  localparam int TB_SSB  = 12;

  localparam int SB_WRDY = 4;
  localparam int SB_RRDY = 5;
  localparam int SB_ERR  = 15;

  // Enough free entries for a whole block while blocks remain
  function automatic logic room_for_block(input logic [31:0] used, input logic [31:0] depth,
                                          input logic [31:0] blen, input logic [31:0] left);
    return (left != 0) && (blen != 0) && ((depth - used) >= blen);
  endfunction

  // A whole block stored while blocks remain
  function automatic logic block_present(input logic [31:0] used, input logic [31:0] blen,
                                         input logic [31:0] left);
    return (left != 0) && (blen != 0) && (used >= blen);
  endfunction
endpackage

// File: rtl/sdh_st_testreg.sv
module sdh_st_testreg
  import sdh_st_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        test_mode_i,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  input  logic        func_obi_i,
  input  logic        func_cd_i,
  input  logic        func_wp_i,
  input  logic        func_wake_i,
  output logic        pin_obi_o,
  output logic        pin_cd_o,
  output logic        pin_wp_o,
  output logic        pin_wake_o,
  output logic [31:0] rdata_o,
  output logic        ssb_o,
  output logic        force_o
);
  logic obi_q, cd_q, wp_q, wake_q, ssb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      obi_q  <= 1'b0;
      cd_q   <= 1'b0;
      wp_q   <= 1'b0;
      wake_q <= 1'b0;
      ssb_q  <= 1'b0;
    end else if (wr_i) begin
      obi_q  <= wdata_i[TB_OBI];
      cd_q   <= wdata_i[TB_CD];
      wp_q   <= wdata_i[TB_WP];
      wake_q <= wdata_i[TB_WAKE];
      ssb_q  <= wdata_i[TB_SSB];
    end
  end

  always_comb begin
    rdata_o          = '0;
    rdata_o[TB_OBI]  = obi_q;
    rdata_o[TB_CD]   = cd_q;
    rdata_o[TB_WP]   = wp_q;
    rdata_o[TB_WAKE] = wake_q;
    rdata_o[TB_SSB]  = ssb_q;
  end

  assign pin_obi_o  = test_mode_i ? obi_q  : func_obi_i;
  assign pin_cd_o   = test_mode_i ? cd_q   : func_cd_i;
  assign pin_wp_o   = test_mode_i ? wp_q   : func_wp_i;
  assign pin_wake_o = test_mode_i ? wake_q : func_wake_i;

  assign ssb_o   = ssb_q;
  assign force_o = wr_i & wdata_i[TB_SSB];
endmodule

// File: rtl/sdh_st_stack.sv
module sdh_st_stack
  import sdh_st_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_mode_i,
  input  logic              dir_rd_i,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              blk_wr_i,
  input  logic [31:0]       blk_wdata_i,
  output logic [DATA_W-1:0] top_o,
  output logic [LW:0]       level_o,
  output logic [LEN_W-1:0]  blen_o,
  output logic [CNT_W-1:0]  left_o,
  output logic              wr_ready_o,
  output logic              rd_ready_o,
  output logic              err_o
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [LW:0]       level_q;
  logic [LEN_W-1:0]  blen_q, wcnt_q;
  logic [CNT_W-1:0]  left_q;
  logic full, empty, push_ok, pop_ok, step, last;
  logic [LW-1:0] top_idx;

  assign full    = (level_q == (LW+1)'(DEPTH));
  assign empty   = (level_q == '0);
  assign push_ok = push_i & ~full;
  assign pop_ok  = pop_i & ~push_i & ~empty;
  assign err_o   = (push_i & full) | (pop_i & ~push_i & empty);
  assign step    = ((push_ok & ~dir_rd_i) | (pop_ok & dir_rd_i)) &
                   (left_q != '0) & (blen_q != '0);
  assign last    = step & ((wcnt_q + LEN_W'(1)) == blen_q);
  assign top_idx = LW'(level_q - (LW+1)'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      blen_q  <= '0;
      wcnt_q  <= '0;
      left_q  <= '0;
    end else begin
      if (push_ok)     level_q <= level_q + (LW+1)'(1);
      else if (pop_ok) level_q <= level_q - (LW+1)'(1);
      if (blk_wr_i) begin
        blen_q <= blk_wdata_i[LEN_W-1:0];
        left_q <= blk_wdata_i[31:16];
        wcnt_q <= '0;
      end else if (last) begin
        wcnt_q <= '0;
        left_q <= left_q - CNT_W'(1);
      end else if (step) begin
        wcnt_q <= wcnt_q + LEN_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[level_q[LW-1:0]] <= push_data_i;
  end

  assign top_o      = empty ? '0 : mem[top_idx];
  assign level_o    = level_q;
  assign blen_o     = blen_q;
  assign left_o     = left_q;
  assign wr_ready_o = test_mode_i & ~dir_rd_i &
                      room_for_block(32'(level_q), 32'(DEPTH), 32'(blen_q), 32'(left_q));
  assign rd_ready_o = test_mode_i & dir_rd_i &
                      block_present(32'(level_q), 32'(blen_q), 32'(left_q));
endmodule

// File: rtl/sdh_st_status.sv
module sdh_st_status
  import sdh_st_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_wr_i,
  input  logic              en_wr_i,
  input  logic [STAT_W-1:0] wdata_i,
  input  logic              ssb_i,
  input  logic              force_i,
  input  logic [STAT_W-1:0] evt_i,
  output logic [STAT_W-1:0] stat_o,
  output logic [STAT_W-1:0] en_o,
  output logic              irq_o
);
  logic [STAT_W-1:0] stat_q, en_q, clr, set;

  assign clr = (stat_wr_i & ~ssb_i) ? wdata_i : '0;
  assign set = evt_i | (force_i ? en_q : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= (stat_q & ~clr) | set;
      if (en_wr_i) en_q <= wdata_i;
    end
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign irq_o  = |(stat_q & en_q);
endmodule

// File: rtl/sdh_systest.sv
module sdh_systest
  import sdh_st_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        test_mode_i,
  input  logic        reg_wr_i,
  input  logic        reg_rd_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        func_obi_i,
  input  logic        func_cd_i,
  input  logic        func_wp_i,
  input  logic        func_wake_i,
  output logic        pin_obi_o,
  output logic        pin_cd_o,
  output logic        pin_wp_o,
  output logic        pin_wake_o,
  output logic        xfer_start_o,
  output logic        irq_o,
  output logic        dma_req_o
);
  localparam int LW = $clog2(DEPTH);

  logic wr_cmd, blk_wr, wr_stat, wr_sen, wr_test, wr_data, wr_ctrl, rd_data;
  logic push, pop, ssb, force_set, err, wr_ready, rd_ready;
  logic wr_rdy_q, rd_rdy_q, xfer_q;
  logic [1:0]        ctrl_q;
  logic              dma_en, dir_rd;
  logic [31:0]       test_rdata;
  logic [DATA_W-1:0] top_word;
  logic [LW:0]       level;
  logic [LEN_W-1:0]  blen;
  logic [CNT_W-1:0]  blk_left;
  logic [STAT_W-1:0] stat, en, evt;

  assign wr_cmd  = reg_wr_i & (reg_addr_i == ADR_CMD);
  assign blk_wr  = reg_wr_i & (reg_addr_i == ADR_BLK);
  assign wr_stat = reg_wr_i & (reg_addr_i == ADR_STAT);
  assign wr_sen  = reg_wr_i & (reg_addr_i == ADR_SEN);
  assign wr_test = reg_wr_i & (reg_addr_i == ADR_TEST);
  assign wr_data = reg_wr_i & (reg_addr_i == ADR_DATA);
  assign wr_ctrl = reg_wr_i & (reg_addr_i == ADR_CTRL);
  assign rd_data = reg_rd_i & ~reg_wr_i & (reg_addr_i == ADR_DATA);
  assign push    = wr_data & test_mode_i;
  assign pop     = rd_data & test_mode_i;
  assign dma_en  = ctrl_q[0];
  assign dir_rd  = ctrl_q[1];

  sdh_st_testreg u_test (
    .clk(clk), .rst_n(rst_n), .test_mode_i(test_mode_i),
    .wr_i(wr_test), .wdata_i(reg_wdata_i),
    .func_obi_i(func_obi_i), .func_cd_i(func_cd_i),
    .func_wp_i(func_wp_i), .func_wake_i(func_wake_i),
    .pin_obi_o(pin_obi_o), .pin_cd_o(pin_cd_o),
    .pin_wp_o(pin_wp_o), .pin_wake_o(pin_wake_o),
    .rdata_o(test_rdata), .ssb_o(ssb), .force_o(force_set)
  );

  sdh_st_stack #(.DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n), .test_mode_i(test_mode_i), .dir_rd_i(dir_rd),
    .push_i(push), .pop_i(pop), .push_data_i(reg_wdata_i),
    .blk_wr_i(blk_wr), .blk_wdata_i(reg_wdata_i),
    .top_o(top_word), .level_o(level), .blen_o(blen), .left_o(blk_left),
    .wr_ready_o(wr_ready), .rd_ready_o(rd_ready), .err_o(err)
  );

  always_comb begin
    evt          = '0;
    evt[SB_WRDY] = wr_ready & ~wr_rdy_q;
    evt[SB_RRDY] = rd_ready & ~rd_rdy_q;
    evt[SB_ERR]  = err;
  end

  sdh_st_status u_status (
    .clk(clk), .rst_n(rst_n), .stat_wr_i(wr_stat), .en_wr_i(wr_sen),
    .wdata_i(reg_wdata_i[STAT_W-1:0]), .ssb_i(ssb), .force_i(force_set),
    .evt_i(evt), .stat_o(stat), .en_o(en), .irq_o(irq_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      xfer_q   <= 1'b0;
      wr_rdy_q <= 1'b0;
      rd_rdy_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= reg_wdata_i[1:0];
      xfer_q   <= wr_cmd & ~test_mode_i;
      wr_rdy_q <= wr_ready;
      rd_rdy_q <= rd_ready;
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      ADR_BLK:  reg_rdata_o = {blk_left, 5'b0, blen};
      ADR_STAT: reg_rdata_o = {16'b0, stat};
      ADR_SEN:  reg_rdata_o = {16'b0, en};
      ADR_TEST: reg_rdata_o = test_rdata;
      ADR_DATA: reg_rdata_o = test_mode_i ? top_word : '0;
      ADR_CTRL: reg_rdata_o = {30'b0, ctrl_q};
      default:  reg_rdata_o = '0;
    endcase
  end

  assign xfer_start_o = xfer_q;
  assign dma_req_o    = dma_en & (wr_ready | rd_ready);
endmodule

// File: rtl/sdh_systest_chk.sv
module sdh_systest_chk #(
  parameter int DEPTH = 16,
  localparam int LW   = $clog2(DEPTH)
) (
  input logic        clk,
  input logic        rst_n,
  input logic        test_mode_i,
  input logic        xfer_start_o,
  input logic        dma_req_o,
  input logic        dma_en,
  input logic [LW:0] level,
  input logic [15:0] blk_left,
  input logic        blk_wr,
  input logic        ssb,
  input logic [15:0] stat,
  input logic [15:0] en
);
  // R3
  xfer_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start_o |-> !$past(test_mode_i));

  // R5
  stack_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= (LW+1)'(DEPTH));

  // R8
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_wr |=> (blk_left <= $past(blk_left)));

  // R9
  dma_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req_o |-> (dma_en && test_mode_i));

  // R10
  force_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ssb) |-> ((stat & en) == en));

  // R11
  clear_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ssb |=> ((stat & $past(stat)) == $past(stat)));
endmodule

bind sdh_systest sdh_systest_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .test_mode_i(test_mode_i),
  .xfer_start_o(xfer_start_o), .dma_req_o(dma_req_o), .dma_en(dma_en),
  .level(level), .blk_left(blk_left), .blk_wr(blk_wr), .ssb(ssb),
  .stat(stat), .en(en)
);

// File: tb/sdh_systest_tb_top.sv
module sdh_systest_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A_CMD = 0, A_BLK = 1, A_STAT = 2, A_SEN = 3,
                         A_TEST = 4, A_DATA = 5, A_CTRL = 6;
  localparam logic [1:0] OP_W = 0, OP_R = 1, OP_M = 2;
  localparam int NV = 26;
  // {op, addr, data, expected}
  localparam logic [68:0] VEC [NV] = '{
    {OP_M, A_CMD,  32'h1,        32'h0},
    {OP_W, A_TEST, 32'hFFFFEFFF, 32'h0},
    {OP_R, A_TEST, 32'h0,        32'h0001E000},  // R1
    {OP_W, A_TEST, 32'h0,        32'h0},
    {OP_R, A_TEST, 32'h0,        32'h0},         // R1
    {OP_W, A_CTRL, 32'h0,        32'h0},
    {OP_W, A_BLK,  32'h00020002, 32'h0},
    {OP_R, A_STAT, 32'h0,        32'h00000010},  // R6
    {OP_W, A_STAT, 32'hFFFF,     32'h0},
    {OP_R, A_STAT, 32'h0,        32'h0},
    {OP_W, A_DATA, 32'hA,        32'h0},
    {OP_W, A_DATA, 32'hB,        32'h0},
    {OP_W, A_DATA, 32'hC,        32'h0},
    {OP_W, A_DATA, 32'hD,        32'h0},
    {OP_R, A_STAT, 32'h0,        32'h0},         // R8
    {OP_W, A_CTRL, 32'h2,        32'h0},
    {OP_W, A_BLK,  32'h00020002, 32'h0},
    {OP_R, A_STAT, 32'h0,        32'h00000020},  // R7
    {OP_R, A_DATA, 32'h0,        32'hD},         // R4
    {OP_R, A_DATA, 32'h0,        32'hC},
    {OP_R, A_DATA, 32'h0,        32'hB},
    {OP_R, A_DATA, 32'h0,        32'hA},
    {OP_R, A_DATA, 32'h0,        32'h0},         // R5
    {OP_R, A_STAT, 32'h0,        32'h00008020},  // R5
    {OP_W, A_STAT, 32'hFFFF,     32'h0},
    {OP_R, A_STAT, 32'h0,        32'h0}
  };

  logic clk = 0, rst_n = 0, test_mode = 0, wr = 0, rd = 0;
  logic [2:0] addr = 0;
  logic [31:0] wdata = 0, rdata, v;
  logic f_obi = 1, f_cd = 0, f_wp = 1, f_wake = 0;
  logic p_obi, p_cd, p_wp, p_wake, xfer, irq, dma;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdh_systest dut_i (
    .clk(clk), .rst_n(rst_n), .test_mode_i(test_mode),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata),
    .func_obi_i(f_obi), .func_cd_i(f_cd), .func_wp_i(f_wp), .func_wake_i(f_wake),
    .pin_obi_o(p_obi), .pin_cd_o(p_cd), .pin_wp_o(p_wp), .pin_wake_o(p_wake),
    .xfer_start_o(xfer), .irq_o(irq), .dma_req_o(dma)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state
    rd_reg(A_TEST, v); check("R1 reset test reg", v, 32'h0);
    rd_reg(A_STAT, v); check("R1 reset status", v, 32'h0);
    check("R2 reset pins follow functional", {p_obi, p_cd, p_wp, p_wake}, 4'b1010);
    check("R12 reset irq", irq, 1'b0);
    check("R9 reset dma", dma, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [68:0] e;
      e = VEC[i];
      case (e[68:67])
        OP_M: begin @(negedge clk); test_mode = e[32]; end
        OP_W: wr_reg(e[66:64], e[63:32]);
        default: begin
          rd_reg(e[66:64], v);
          check($sformatf("R4-table step %0d (R1 R5 R6 R7 R8)", i), v, e[31:0]);
        end
      endcase
    end

    // force-set and clear blocking
    wr_reg(A_SEN, 32'h00F0);
    check("R12 irq low with empty status", irq, 1'b0);
    wr_reg(A_TEST, 32'h1000);
    rd_reg(A_STAT, v); check("R10 force sets enabled bits only", v, 32'h00F0);
    check("R12 irq high", irq, 1'b1);
    wr_reg(A_STAT, 32'hFFFF);
    rd_reg(A_STAT, v); check("R11 clear blocked while force set", v, 32'h00F0);
    wr_reg(A_TEST, 32'h0);
    rd_reg(A_STAT, v); check("R11 writing 0 keeps status", v, 32'h00F0);
    rd_reg(A_TEST, v); check("R11 force bit cleared", v, 32'h0);
    wr_reg(A_STAT, 32'hFFFF);
    rd_reg(A_STAT, v); check("R11 clear works after force cleared", v, 32'h0);
    check("R12 irq low after clear", irq, 1'b0);
    wr_reg(A_SEN, 32'h0);

    // DMA pacing
    wr_reg(A_CTRL, 32'h0);
    wr_reg(A_BLK, 32'h00010004);
    check("R9 dma off when disabled", dma, 1'b0);
    wr_reg(A_CTRL, 32'h1);
    check("R9 dma on when space ready", dma, 1'b1);
    for (int k = 0; k < 4; k++) wr_reg(A_DATA, 32'(k + 100));
    check("R8 dma off at count zero", dma, 1'b0);
    for (int k = 0; k < 4; k++) rd_reg(A_DATA, v);
    wr_reg(A_CTRL, 32'h0);
    wr_reg(A_STAT, 32'hFFFF);

    // overflow
    for (int k = 1; k <= 17; k++) wr_reg(A_DATA, 32'(k));
    rd_reg(A_STAT, v); check("R5 overflow flag", v, 32'h8000);
    rd_reg(A_DATA, v); check("R5 dropped push", v, 32'd16);

    // pins
    wr_reg(A_TEST, 32'h0001E000);
    check("R2 pins driven high", {p_obi, p_cd, p_wp, p_wake}, 4'b1111);
    wr_reg(A_TEST, 32'h0000A000);
    check("R2 pins per bit", {p_obi, p_cd, p_wp, p_wake}, 4'b0101);
    @(negedge clk); test_mode = 0;
    #1 check("R2 pins follow functional outside test", {p_obi, p_cd, p_wp, p_wake}, 4'b1010);
    rd_reg(A_TEST, v); check("R2 stored bits kept", v, 32'h0000A000);

    // command start
    wr_reg(A_CMD, 32'h1);
    check("R3 start pulse", xfer, 1'b1);
    @(negedge clk); check("R3 pulse one cycle", xfer, 1'b0);
    test_mode = 1;
    wr_reg(A_CMD, 32'h1);
    check("R3 no start in test mode", xfer, 1'b0);

    finish_run();
  end
endmodule